// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from the release of reset until the memory is ready for normal traffic. It first holds clock enable and the data masks high with a no-operation command on the pins for a long settling interval. It then closes every bank with a precharge-all command. It issues a programmable number of auto-refresh commands and loads the mode register with a caller-supplied opcode. When the last required gap has elapsed, it raises a done flag. The main memory controller takes over the pins once that flag is high.

The settling interval, the number of refreshes and the minimum spacing after each command type are parameters. A parameter also chooses whether the refresh burst or the mode load comes directly after the precharge. Illegal parameter values are rejected during elaboration. Every cycle that does not carry a command carries a no-operation.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 1, every dqm_o bit is 1, the command pins {cs_no,ras_no,cas_no,we_no} read 4'b0111 (no-operation), addr_o and ba_o are 0, and done_o is 0.
- R2: After reset is released, the no-operation command is held for exactly WAIT_CYC cycles. The first command appears in cycle WAIT_CYC, counting the first cycle after release as cycle 0.
- R3: The first command is precharge-all. The pins read 4'b0010, addr_o has only bit AP_BIT (10) set, and ba_o is 0.
- R4: Exactly REF_NUM auto-refresh commands are issued. Each has pins 4'b0001 with addr_o and ba_o at 0. Any command that follows a refresh comes exactly T_RC cycles after it.
- R5: The command after the precharge-all comes exactly T_RP cycles after it.
- R6: The mode-register load drives pins 4'b0000, with addr_o equal to mode_addr_i and ba_o equal to mode_ba_i. When MRS_FIRST is 0 it comes after the last refresh. When MRS_FIRST is 1 it comes directly after the precharge gap, ahead of the refreshes.
- R7: done_o rises exactly T_MRD cycles after the mode load when that load is the last command, or exactly T_RC cycles after the last refresh when MRS_FIRST is 1. Any command that follows the mode load comes exactly T_MRD cycles after it. Once high, done_o stays high until reset.
- R8: In every cycle after release that carries no command, including every gap cycle and every cycle after done_o rises, the pins read no-operation with addr_o and ba_o at 0. cke_o and all dqm_o bits stay 1 throughout.
- R9: Asserting reset at any point of the sequence, including mid-refresh, abandons it. After the next release the whole sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_addr_i | input | ADDR_W | Mode opcode for the address pins |
| mode_ba_i | input | BA_W | Mode opcode for the bank pins |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dqm_o | output | DQM_W | Data masks |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank select |
| done_o | output | 1 | Initialization complete |

## Verification
The hardest case to reach is a reset that lands in the middle of the refresh burst. The refresh counter and the gap timer are then both non-zero, and a stale count would shorten the second run. The bench runs a short-wait instance next to the full-length one. It pulls reset while that instance is between its second and third refresh, then replays the whole expected schedule from cycle 0. Both refresh-first and mode-first orders are scheduled, and a gap of one cycle after the precharge is covered, so the path that skips the gap state is taken as well.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } cmd_e;

  typedef enum logic [2:0] {
    S_WAIT,
    S_PRE,
    S_PRE_GAP,
    S_REF,
    S_REF_GAP,
    S_MRS,
    S_MRS_GAP,
    S_DONE
  } state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int REF_NUM   = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter bit MRS_FIRST = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output state_e           state_o
);

  localparam int RC_W = $clog2(REF_NUM + 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'((T_RP  >= 2) ? T_RP  - 2 : 0);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'((T_RC  >= 2) ? T_RC  - 2 : 0);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'((T_MRD >= 2) ? T_MRD - 2 : 0);

  state_e state_q, state_d;
  state_e after_pre, after_ref, after_mrs;
  logic [RC_W-1:0] ref_cnt_q;
  logic ref_inc, last_ref, refs_done;

  // order variant: which phase follows the precharge
  generate
    if (MRS_FIRST) begin : g_mrs_first
      assign after_pre = S_MRS;
      assign after_mrs = S_REF;
      assign after_ref = S_DONE;
    end else begin : g_ref_first
      assign after_pre = S_REF;
      assign after_ref = S_MRS;
      assign after_mrs = S_DONE;
    end
  endgenerate

  assign last_ref  = (ref_cnt_q == RC_W'(REF_NUM - 1));
  assign refs_done = (ref_cnt_q == RC_W'(REF_NUM));

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    ref_inc    = 1'b0;
    unique case (state_q)
      S_WAIT:    if (zero_i) state_d = S_PRE;
      S_PRE: begin
        if (T_RP == 1) state_d = after_pre;
        else begin
          load_o = 1'b1; load_val_o = LD_RP; state_d = S_PRE_GAP;
        end
      end
      S_PRE_GAP: if (zero_i) state_d = after_pre;
      S_REF: begin
        ref_inc = 1'b1;
        if (T_RC == 1) state_d = last_ref ? after_ref : S_REF;
        else begin
          load_o = 1'b1; load_val_o = LD_RC; state_d = S_REF_GAP;
        end
      end
      S_REF_GAP: if (zero_i) state_d = refs_done ? after_ref : S_REF;
      S_MRS: begin
        load_o = 1'b1; load_val_o = LD_MRD; state_d = S_MRS_GAP;
      end
      S_MRS_GAP: if (zero_i) state_d = after_mrs;
      S_DONE:    state_d = S_DONE;
      default:   state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_WAIT;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sdram_init_cmd_drv.sv
module sdram_init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1,
  parameter int AP_BIT = 10
) (
  input  state_e            state_i,
  input  logic [ADDR_W-1:0] mode_addr_i,
  input  logic [BA_W-1:0]   mode_ba_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_i)
      S_PRE: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = 1'b1;
      end
      S_REF: cmd_o = CMD_REF;
      S_MRS: begin
        cmd_o  = CMD_MRS;
        addr_o = mode_addr_i;
        ba_o   = mode_ba_i;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign done_o = (state_i == S_DONE);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int DQM_W     = 2,
  parameter int AP_BIT    = 10,
  parameter int WAIT_CYC  = 20000,
  parameter int REF_NUM   = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter bit MRS_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_addr_i,
  input  logic [BA_W-1:0]   mode_ba_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  localparam int MAX_A = (WAIT_CYC > T_RC) ? WAIT_CYC : T_RC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_V + 1);

  generate
    if (REF_NUM < 2)        begin : g_bad_ref  $error("REF_NUM must be >= 2");     end
    if (T_MRD < 2)          begin : g_bad_mrd  $error("T_MRD must be >= 2");       end
    if (T_RP < 1)           begin : g_bad_rp   $error("T_RP must be >= 1");        end
    if (T_RC < 1)           begin : g_bad_rc   $error("T_RC must be >= 1");        end
    if (WAIT_CYC < 1)       begin : g_bad_wait $error("WAIT_CYC must be >= 1");    end
    if (AP_BIT >= ADDR_W)   begin : g_bad_ap   $error("AP_BIT outside address");   end
  endgenerate

  logic             zero, load;
  logic [CNT_W-1:0] load_val;
  state_e           state;
  cmd_e             cmd;

  sdram_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(WAIT_CYC - 1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  sdram_init_fsm #(
    .CNT_W    (CNT_W),
    .REF_NUM  (REF_NUM),
    .T_RP     (T_RP),
    .T_RC     (T_RC),
    .T_MRD    (T_MRD),
    .MRS_FIRST(MRS_FIRST)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zero_i    (zero),
    .load_o    (load),
    .load_val_o(load_val),
    .state_o   (state)
  );

  sdram_init_cmd_drv #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .AP_BIT(AP_BIT)
  ) u_drv (
    .state_i    (state),
    .mode_addr_i(mode_addr_i),
    .mode_ba_i  (mode_ba_i),
    .cmd_o      (cmd),
    .addr_o     (addr_o),
    .ba_o       (ba_o),
    .done_o     (done_o)
  );

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign cke_o = 1'b1;
  assign dqm_o = '1;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int DQM_W     = 2,
  parameter int AP_BIT    = 10,
  parameter int REF_NUM   = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter bit MRS_FIRST = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mode_addr_i,
  input logic [BA_W-1:0]   mode_ba_i,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [DQM_W-1:0]  dqm_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              done_o
);

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;
  localparam int DONE_GAP = MRS_FIRST ? T_RC : T_MRD;

  logic [3:0]  pins;
  logic        is_cmd;
  logic [3:0]  last_q;
  logic [15:0] since_q;
  logic [7:0]  refs_q;

  assign pins   = {cs_no, ras_no, cas_no, we_no};
  assign is_cmd = (pins != P_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= P_NOP;
      since_q <= '0;
      refs_q  <= '0;
    end else begin
      if (is_cmd) begin
        last_q  <= pins;
        since_q <= 16'd1;
      end else if (since_q != 16'hFFFF) begin
        since_q <= since_q + 1'b1;
      end
      if (pins == P_REF) refs_q <= refs_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (cke_o && (&dqm_o) && pins == P_NOP && !done_o
                                && addr_o == '0 && ba_o == '0);
    end
  end

  a_r8_cke_dqm_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o && (&dqm_o));
  a_r8_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pins == P_NOP && addr_o == '0));
  a_r3_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == P_PRE) |-> addr_o[AP_BIT]);
  a_r5_pre_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == P_PRE) |-> (since_q == 16'(T_RP)));
  a_r4_ref_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == P_REF) |-> (since_q == 16'(T_RC)));
  a_r7_mrs_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == P_MRS) |-> (since_q == 16'(T_MRD)));
  a_r7_done_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (since_q == 16'(DONE_GAP)));
  a_r4_ref_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (refs_q == 8'(REF_NUM)));
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r6_mrs_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == P_MRS) |-> (addr_o == mode_addr_i && ba_o == mode_ba_i));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT),
  .REF_NUM(REF_NUM), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
  .MRS_FIRST(MRS_FIRST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_addr_i(mode_addr_i),
  .mode_ba_i(mode_ba_i), .cke_o(cke_o), .cs_no(cs_no), .ras_no(ras_no),
  .cas_no(cas_no), .we_no(we_no), .dqm_o(dqm_o), .addr_o(addr_o),
  .ba_o(ba_o), .done_o(done_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int AW = 11;
  // instance A: defaults, refresh first
  localparam int A_WAIT = 20000, A_REF = 2, A_RP = 3, A_RC = 7, A_MRD = 2;
  // instance B: short wait, mode first, one-cycle precharge gap
  localparam int B_WAIT = 40, B_REF = 3, B_RP = 1, B_RC = 4, B_MRD = 2;

  localparam logic [3:0] E_NOP = 4'b0111, E_PRE = 4'b0010,
                         E_REF = 4'b0001, E_MRS = 4'b0000;

  typedef struct packed {
    int         cyc;
    logic [3:0] cmd;
    logic [10:0] addr;
    logic       ba;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [AW-1:0] mode_addr = 11'h032;
  logic          mode_ba = 1'b0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done, a_ba;
  logic [1:0] a_dqm;
  logic [AW-1:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done, b_ba;
  logic [1:0] b_dqm;
  logic [AW-1:0] b_addr;

  int checks = 0, errors = 0;
  int cyc = 0;
  int total = 0;
  int a_done_cyc = -1, b_done_cyc = -1;
  exp_t qa[$];
  exp_t qb[$];

  always #5 clk = ~clk;

  sdram_init_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_addr_i(mode_addr), .mode_ba_i(mode_ba),
    .cke_o(a_cke), .cs_no(a_cs), .ras_no(a_ras), .cas_no(a_cas), .we_no(a_we),
    .dqm_o(a_dqm), .addr_o(a_addr), .ba_o(a_ba), .done_o(a_done)
  );

  sdram_init_seq #(
    .WAIT_CYC(B_WAIT), .REF_NUM(B_REF), .T_RP(B_RP), .T_RC(B_RC),
    .T_MRD(B_MRD), .MRS_FIRST(1'b1)
  ) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .mode_addr_i(mode_addr), .mode_ba_i(mode_ba),
    .cke_o(b_cke), .cs_no(b_cs), .ras_no(b_ras), .cas_no(b_cas), .we_no(b_we),
    .dqm_o(b_dqm), .addr_o(b_addr), .ba_o(b_ba), .done_o(b_done)
  );

  always @(posedge clk) begin
    total <= total + 1;
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic exp_t mk(input int c, input logic [3:0] k,
                              input logic [10:0] a, input logic b);
    exp_t e;
    e.cyc = c; e.cmd = k; e.addr = a; e.ba = b;
    return e;
  endfunction

  // driver: push the expected schedule of both instances
  task automatic plan();
    int c;
    qa.delete(); qb.delete();
    c = A_WAIT;
    qa.push_back(mk(c, E_PRE, 11'h400, 1'b0)); c += A_RP;
    for (int i = 0; i < A_REF; i++) begin
      qa.push_back(mk(c, E_REF, '0, 1'b0)); c += A_RC;
    end
    qa.push_back(mk(c, E_MRS, mode_addr, mode_ba)); c += A_MRD;
    a_done_cyc = c;
    c = B_WAIT;
    qb.push_back(mk(c, E_PRE, 11'h400, 1'b0)); c += B_RP;
    qb.push_back(mk(c, E_MRS, mode_addr, mode_ba)); c += B_MRD;
    for (int i = 0; i < B_REF; i++) begin
      qb.push_back(mk(c, E_REF, '0, 1'b0)); c += B_RC;
    end
    b_done_cyc = c;
  endtask

  // monitor A
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] p;
      exp_t e;
      p = {a_cs, a_ras, a_cas, a_we};
      chk(a_cke && (&a_dqm), "R8 A cke/dqm", {a_cke, a_dqm}, 3'b111);
      chk(a_done == (a_done_cyc >= 0 && cyc >= a_done_cyc), "R7 A done",
          a_done, cyc >= a_done_cyc);
      if (p != E_NOP) begin
        if (qa.size() == 0) chk(1'b0, "R4 A unexpected cmd", p, E_NOP);
        else begin
          e = qa.pop_front();
          chk(cyc == e.cyc, "R2/R5/R4 A cmd cycle", cyc, e.cyc);
          chk(p == e.cmd, "R3/R4/R6 A cmd code", p, e.cmd);
          chk(a_addr == e.addr && a_ba == e.ba, "R3/R6 A addr/ba",
              {a_ba, a_addr}, {e.ba, e.addr});
        end
      end else begin
        chk(a_addr == '0 && a_ba == 1'b0, "R8 A nop addr", {a_ba, a_addr}, 0);
      end
    end
  end

  // monitor B
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] p;
      exp_t e;
      p = {b_cs, b_ras, b_cas, b_we};
      chk(b_cke && (&b_dqm), "R8 B cke/dqm", {b_cke, b_dqm}, 3'b111);
      chk(b_done == (b_done_cyc >= 0 && cyc >= b_done_cyc), "R7 B done",
          b_done, cyc >= b_done_cyc);
      if (p != E_NOP) begin
        if (qb.size() == 0) chk(1'b0, "R4 B unexpected cmd", p, E_NOP);
        else begin
          e = qb.pop_front();
          chk(cyc == e.cyc, "R5/R6/R4 B cmd cycle", cyc, e.cyc);
          chk(p == e.cmd, "R3/R4/R6 B cmd code", p, e.cmd);
          chk(b_addr == e.addr && b_ba == e.ba, "R3/R6 B addr/ba",
              {b_ba, b_addr}, {e.ba, e.addr});
        end
      end else begin
        chk(b_addr == '0 && b_ba == 1'b0, "R8 B nop addr", {b_ba, b_addr}, 0);
      end
    end
  end

  task automatic check_reset_state();
    @(negedge clk);
    chk(a_cke && (&a_dqm) && {a_cs, a_ras, a_cas, a_we} == E_NOP && !a_done
        && a_addr == '0 && a_ba == 1'b0, "R1 A reset state",
        {a_done, a_cs, a_ras, a_cas, a_we}, {1'b0, E_NOP});
    chk(b_cke && (&b_dqm) && {b_cs, b_ras, b_cas, b_we} == E_NOP && !b_done
        && b_addr == '0 && b_ba == 1'b0, "R1 B reset state",
        {b_done, b_cs, b_ras, b_cas, b_we}, {1'b0, E_NOP});
  endtask

  task automatic start_run(input logic [AW-1:0] ma, input logic mb);
    @(negedge clk);
    rst_n = 1'b0;
    a_done_cyc = -1; b_done_cyc = -1;
    mode_addr = ma; mode_ba = mb;
    repeat (3) check_reset_state();
    plan();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    chk(qa.size() == 0, "R4 A schedule drained", qa.size(), 0);
    chk(qb.size() == 0, "R4 B schedule drained", qb.size(), 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // run 1: full sequence on both instances
    start_run(11'h032, 1'b0);
    wait (cyc == a_done_cyc + 30);
    @(negedge clk);
    chk(a_done && b_done, "R7 done still high", {a_done, b_done}, 2'b11);
    finish_run();
    // run 2: reset between the 2nd and 3rd refresh of instance B (R9)
    start_run(11'h7A5, 1'b1);
    wait (cyc == 49);
    @(negedge clk);
    chk(qb.size() == 1, "R9 B mid refresh", qb.size(), 1);
    // run 3: full restart with another opcode
    start_run(11'h1C3, 1'b1);
    wait (cyc == a_done_cyc + 10);
    @(negedge clk);
    finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (total >= 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", total);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule